// File: doc/BRIEF.md
# Nibble-Wide Parallel Register Access Slave

This block is the device side of a narrow host link. A host reaches a small internal register file over one 8-bit data bus and reads back four bits at a time on status lines. Command bytes, register offsets and data nibbles all travel on the same bus.

The upper three bits of each byte give its class:
- `111` ends an access.
- `010` opens a write.
- `110` opens a read.
- `000` carries a bare nibble.

Bit 4 picks the upper or lower nibble, and bits 3:0 carry an offset or a nibble. Hosts send bytes more than once to let slow wiring settle, so the slave acts only on a byte that differs from the one it sampled on the previous clock.

A second mode takes bulk packet data as nibble pairs, low nibble first. Each completed pair is handed to the packet path with a one-cycle strobe. The register contents are also driven out in parallel for the rest of the chip.

Top module: `nib_reg_slave`

## Requirements
- R1: After reset every register reads 0x00, `stat_o` is 0x00 and `bulk_vld_o` is low.
- R2: A byte on `pdata_i` equal to the byte sampled on the previous clock has no effect on registers, access state or the bulk strobe.
- R3: A changed byte whose bits 7:5 are `111` returns the slave to idle, so `stat_o` becomes 0x00. In idle, nibble bytes (class `000`) write nothing.
- R4: In register mode, a `010` byte received outside a write access opens a write to the offset in bits 3:0. While the write is open, each changed `010` or `000` byte is a data nibble. With bit 4 clear, bits 3:0 go to register bits 3:0. With bit 4 set, they go to register bits 7:4.
- R5: In register mode, a changed `110` byte opens a read of the offset in bits 3:0. From the next cycle, `stat_o[6:3]` shows register bits 7:4 if bit 4 of that byte was set, else bits 3:0. It tracks later writes to that register.
- R6: `stat_o` bits 7 and 2:0 are always 0, and `stat_o` is 0x00 whenever no read is open.
- R7: With `bulk_en_i` high, a changed `000` byte with bit 4 clear holds a low nibble. A following changed `000` byte with bit 4 set raises `bulk_vld_o` for one cycle, with `bulk_byte_o` = {high nibble, low nibble}. A 16-bit word sent as four nibbles yields its low byte first.
- R8: In bulk mode, a high nibble with no held low nibble produces no strobe. A `111` byte discards a held low nibble.
- R9: With `bulk_en_i` high, `010` and `110` bytes neither open accesses nor write registers.
- R10: Bytes of class `001`, `011`, `100` or `101` are ignored in both modes.
- R11: `regs_o[8*i+7:8*i]` is register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pdata_i | input | 8 | Host data bus: class, nibble select, offset or nibble |
| bulk_en_i | input | 1 | High selects bulk packet mode |
| stat_o | output | 8 | Status lines, read nibble on bits 6:3 |
| bulk_vld_o | output | 1 | One-cycle strobe for an assembled bulk byte |
| bulk_byte_o | output | 8 | Assembled bulk byte |
| regs_o | output | 8*NREG | Register file contents, register i at bits 8i+7:8i |

## Verification
The bench sends the host's padded sequences:
- The repeated address byte. A design that wrote on every clock would write it again as data.
- A data nibble that equals the offset. It is only honoured once its prefix is stripped, so a design that compared nibbles instead of bytes would miss it.
- A high nibble sent alone.
- An end byte between two halves of a bulk byte. A design that kept the stale low nibble would strobe a wrong byte.
- Address bytes while bulk mode is on. A leaky decoder would corrupt registers.

Random traffic with mixed classes and mode switches is compared against a bench model after every byte.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam int NIB_W = 4;
  localparam logic [2:0] CLS_DATA = 3'b000;
  localparam logic [2:0] CLS_WR   = 3'b010;
  localparam logic [2:0] CLS_RD   = 3'b110;
  localparam logic [2:0] CLS_END  = 3'b111;
  localparam logic [7:0] IDLE_BYTE = 8'hE0;

  typedef enum logic [1:0] {ST_IDLE, ST_WR, ST_RD} acc_st_e;
endpackage

// File: rtl/nib_decode.sv
module nib_decode
  import nib_pkg::*;
#(
  parameter int NREG = 16,
  localparam int AW = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        byte_i,
  input  logic              bulk_en_i,
  output logic              wr_en_o,
  output logic              wr_hi_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [NIB_W-1:0]  nib_o,
  output logic              rd_open_o,
  output logic              rd_hi_o,
  output logic [AW-1:0]     rd_addr_o,
  output logic              end_o,
  output logic              bdat_o
);
  logic [7:0]    last_q;
  acc_st_e       st_q, st_d;
  logic [AW-1:0] off_q, off_d;
  logic          hi_q, hi_d;
  logic          act;
  logic [2:0]    cls;

  assign act = (byte_i != last_q);
  assign cls = byte_i[7:5];

  always_comb begin
    st_d    = st_q;
    off_d   = off_q;
    hi_d    = hi_q;
    wr_en_o = 1'b0;
    if (act) begin
      unique case (cls)
        CLS_END: st_d = ST_IDLE;
        CLS_WR: if (!bulk_en_i) begin
          if (st_q == ST_WR) wr_en_o = 1'b1;
          else begin
            st_d  = ST_WR;
            off_d = byte_i[AW-1:0];
          end
        end
        CLS_RD: if (!bulk_en_i) begin
          st_d  = ST_RD;
          off_d = byte_i[AW-1:0];
          hi_d  = byte_i[4];
        end
        CLS_DATA: if (!bulk_en_i && st_q == ST_WR) wr_en_o = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= IDLE_BYTE;
      st_q   <= ST_IDLE;
      off_q  <= '0;
      hi_q   <= 1'b0;
    end else begin
      last_q <= byte_i;
      st_q   <= st_d;
      off_q  <= off_d;
      hi_q   <= hi_d;
    end
  end

  assign wr_hi_o   = byte_i[4];
  assign wr_addr_o = off_q;
  assign nib_o     = byte_i[NIB_W-1:0];
  assign rd_open_o = (st_q == ST_RD);
  assign rd_hi_o   = hi_q;
  assign rd_addr_o = off_q;
  assign end_o     = act && (cls == CLS_END);
  assign bdat_o    = act && (cls == CLS_DATA) && bulk_en_i;
endmodule

// File: rtl/nib_regfile.sv
module nib_regfile
  import nib_pkg::*;
#(
  parameter int NREG = 16,
  parameter int DW   = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_hi_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [NIB_W-1:0]  wr_nib_i,
  input  logic              rd_hi_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [NIB_W-1:0]  rd_nib_o,
  output logic [NREG*DW-1:0] regs_o
);
  logic [DW-1:0] mem_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= '0;
      else if (wr_en_i && wr_addr_i == AW'(i)) begin
        if (wr_hi_i) mem_q[i][DW-1:NIB_W] <= wr_nib_i;
        else         mem_q[i][NIB_W-1:0]  <= wr_nib_i;
      end
    end
    assign regs_o[i*DW +: DW] = mem_q[i];
  end

  assign rd_nib_o = rd_hi_i ? mem_q[rd_addr_i][DW-1:NIB_W] : mem_q[rd_addr_i][NIB_W-1:0];
endmodule

// File: rtl/nib_bulk.sv
module nib_bulk
  import nib_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dat_i,
  input  logic             hi_i,
  input  logic [NIB_W-1:0] nib_i,
  input  logic             clr_i,
  output logic             vld_o,
  output logic [7:0]       byte_o
);
  logic [NIB_W-1:0] lo_q;
  logic             lo_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      lo_v_q <= 1'b0;
      vld_o  <= 1'b0;
      byte_o <= '0;
    end else begin
      vld_o <= 1'b0;
      if (clr_i) lo_v_q <= 1'b0;
      else if (dat_i && !hi_i) begin
        lo_q   <= nib_i;
        lo_v_q <= 1'b1;
      end else if (dat_i && hi_i && lo_v_q) begin
        vld_o  <= 1'b1;
        byte_o <= {nib_i, lo_q};
        lo_v_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nib_reg_slave.sv
module nib_reg_slave
  import nib_pkg::*;
#(
  parameter int NREG = 16,
  localparam int DW  = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [7:0]         pdata_i,
  input  logic               bulk_en_i,
  output logic [7:0]         stat_o,
  output logic               bulk_vld_o,
  output logic [7:0]         bulk_byte_o,
  output logic [NREG*DW-1:0] regs_o
);
  logic             wr_en, wr_hi, rd_open, rd_hi, end_b, bdat;
  logic [AW-1:0]    wr_addr, rd_addr;
  logic [NIB_W-1:0] nib, rd_nib;

  nib_decode #(.NREG(NREG)) i_decode (
    .clk_i, .rst_ni, .byte_i(pdata_i), .bulk_en_i,
    .wr_en_o(wr_en), .wr_hi_o(wr_hi), .wr_addr_o(wr_addr), .nib_o(nib),
    .rd_open_o(rd_open), .rd_hi_o(rd_hi), .rd_addr_o(rd_addr),
    .end_o(end_b), .bdat_o(bdat)
  );

  nib_regfile #(.NREG(NREG), .DW(DW)) i_regfile (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_hi_i(wr_hi), .wr_addr_i(wr_addr),
    .wr_nib_i(nib), .rd_hi_i(rd_hi), .rd_addr_i(rd_addr),
    .rd_nib_o(rd_nib), .regs_o
  );

  nib_bulk i_bulk (
    .clk_i, .rst_ni, .dat_i(bdat), .hi_i(wr_hi), .nib_i(nib), .clr_i(end_b),
    .vld_o(bulk_vld_o), .byte_o(bulk_byte_o)
  );

  // read nibble rides on status lines 6:3
  assign stat_o = {1'b0, rd_open ? rd_nib : 4'h0, 3'b000};
endmodule

// File: rtl/nib_reg_slave_chk.sv
module nib_reg_slave_chk #(
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [7:0]        pdata_i,
  input logic              bulk_en_i,
  input logic [7:0]        stat_o,
  input logic              bulk_vld_o,
  input logic [NREG*8-1:0] regs_o
);
  // R7
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bulk_vld_o |=> !bulk_vld_o);

  // R3
  end_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdata_i[7:5] == 3'b111 |=> stat_o == 8'h00);

  // R2
  repeat_noop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(pdata_i) |=> ($stable(regs_o) && !bulk_vld_o));

  // R9
  bulk_noreg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bulk_en_i |=> $stable(regs_o));

  // R5
  rd_nibble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdata_i[7:5] == 3'b110 && !bulk_en_i && pdata_i != $past(pdata_i))
    |=> stat_o[6:3] == regs_o[{$past(pdata_i[AW-1:0]), $past(pdata_i[4]), 2'b00} +: 4]);
endmodule

bind nib_reg_slave nib_reg_slave_chk #(.NREG(NREG)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pdata_i(pdata_i), .bulk_en_i(bulk_en_i),
  .stat_o(stat_o), .bulk_vld_o(bulk_vld_o), .regs_o(regs_o)
);

// File: tb/test_nib_reg_slave.sv
module test_nib_reg_slave;
  localparam int NREG = 16;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [7:0]        pdata = 8'hE0;
  logic              bulk_en = 1'b0;
  logic [7:0]        stat;
  logic              bvld;
  logic [7:0]        bbyte;
  logic [NREG*8-1:0] regs;

  int tests = 0, fails = 0;
  bit done = 0;

  nib_reg_slave #(.NREG(NREG)) i_nib_reg_slave (
    .clk_i(clk), .rst_ni(rst_ni), .pdata_i(pdata), .bulk_en_i(bulk_en),
    .stat_o(stat), .bulk_vld_o(bvld), .bulk_byte_o(bbyte), .regs_o(regs)
  );

  always #5 clk = ~clk;

  // bench model state
  logic [7:0] m_regs [NREG];
  int         m_st;            // 0 idle, 1 write, 2 read
  logic [3:0] m_off;
  logic       m_hi;
  logic [7:0] m_last;
  logic [3:0] m_lo;
  logic       m_lov;
  logic       e_vld;
  logic [7:0] e_byte;

  function automatic logic [NREG*8-1:0] m_flat();
    logic [NREG*8-1:0] f;
    for (int i = 0; i < NREG; i++) f[i*8 +: 8] = m_regs[i];
    return f;
  endfunction

  function automatic logic [7:0] m_stat();
    logic [7:0] r = m_regs[m_off];
    if (m_st != 2) return 8'h00;
    return {1'b0, m_hi ? r[7:4] : r[3:0], 3'b000};
  endfunction

  task automatic m_reset();
    for (int i = 0; i < NREG; i++) m_regs[i] = 8'h00;
    m_st = 0; m_off = 0; m_hi = 0; m_last = 8'hE0; m_lo = 0; m_lov = 0;
    e_vld = 0; e_byte = 0;
  endtask

  task automatic m_step(input logic [7:0] b, input logic bm);
    logic [2:0] c = b[7:5];
    e_vld = 0;
    if (b != m_last) begin
      if (c == 3'b111) begin
        m_st = 0; m_lov = 0;
      end else if (c == 3'b010 && !bm) begin
        if (m_st == 1) begin
          if (b[4]) m_regs[m_off][7:4] = b[3:0]; else m_regs[m_off][3:0] = b[3:0];
        end else begin
          m_st = 1; m_off = b[3:0];
        end
      end else if (c == 3'b110 && !bm) begin
        m_st = 2; m_off = b[3:0]; m_hi = b[4];
      end else if (c == 3'b000) begin
        if (bm) begin
          if (!b[4]) begin m_lo = b[3:0]; m_lov = 1; end
          else if (m_lov) begin e_vld = 1; e_byte = {b[3:0], m_lo}; m_lov = 0; end
        end else if (m_st == 1) begin
          if (b[4]) m_regs[m_off][7:4] = b[3:0]; else m_regs[m_off][3:0] = b[3:0];
        end
      end
    end
    m_last = b;
  endtask

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one byte at a falling edge, check after the next rising edge
  task automatic put(input logic [7:0] b, input logic bm);
    pdata = b; bulk_en = bm;
    m_step(b, bm);
    @(posedge clk); #1;
    chk("R5/R6 stat", 128'(stat), 128'(m_stat()));
    chk("R7 strobe", 128'(bvld), 128'(e_vld));
    if (e_vld) chk("R7 byte", 128'(bbyte), 128'(e_byte));
    chk("R4 regs", 128'(regs), 128'(m_flat()));
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] snap;
    int unsigned seed;
    m_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1
    chk("R1 regs", 128'(regs), 128'h0);
    chk("R1 stat", 128'(stat), 128'h0);
    chk("R1 strobe", 128'(bvld), 128'h0);
    @(negedge clk);

    // R4 full-byte write to register 3, with padding repeats
    put(8'hE3, 0); put(8'h43, 0); put(8'h43, 0);
    put(8'h45, 0); put(8'h05, 0); put(8'h1A, 0); put(8'h1A, 0); put(8'hEA, 0);
    chk("R11 reg3", 128'(regs[3*8 +: 8]), 128'hA5);

    // R2 data nibble equal to offset only lands once prefix stripped
    put(8'hE7, 0); put(8'h47, 0); put(8'h47, 0); put(8'h47, 0);
    chk("R2 repeat no write", 128'(regs[7*8 +: 8]), 128'h00);
    put(8'h07, 0); put(8'hE7, 0);
    chk("R4 low nibble", 128'(regs[7*8 +: 8]), 128'h07);

    // R5 reads
    put(8'hE0, 0); put(8'hC3, 0);
    chk("R5 low read", 128'(stat), 128'(8'h5 << 3));
    put(8'hD3, 0);
    chk("R5 high read", 128'(stat), 128'(8'hA << 3));
    put(8'hE0, 0);
    chk("R3 end clears stat", 128'(stat), 128'h0);
    chk("R6 idle stat", 128'(stat), 128'h0);

    // R3 nibble while idle ignored
    put(8'h05, 0); put(8'h15, 0);
    chk("R3 idle nibble", 128'(regs), 128'(m_flat()));
    chk("R3 reg0 untouched", 128'(regs[7:0]), 128'h00);

    // R10 odd classes ignored inside a write
    put(8'hE2, 0); put(8'h42, 0); put(8'h85, 0); put(8'h39, 0); put(8'hA6, 0);
    chk("R10 reg2", 128'(regs[2*8 +: 8]), 128'h00);
    put(8'hE0, 0);

    // R7 bulk pair and word
    put(8'h03, 1); put(8'h1C, 1);
    chk("R7 pair", 128'(bbyte), 128'hC3);
    put(8'h1F, 1);
    chk("R8 lone high", 128'(bvld), 128'h0);
    put(8'h04, 1); put(8'hE0, 1); put(8'h15, 1);
    chk("R8 end clears low", 128'(bvld), 128'h0);
    put(8'h04, 1); put(8'h13, 1);
    chk("R7 word low byte", 128'(bbyte), 128'h34);
    put(8'h02, 1); put(8'h11, 1);
    chk("R7 word high byte", 128'(bbyte), 128'h12);

    // R9 address bytes ignored in bulk mode
    put(8'hE0, 1); put(8'h49, 1); put(8'h46, 1); put(8'h06, 1); put(8'hC9, 1);
    chk("R9 reg9", 128'(regs[9*8 +: 8]), 128'h00);
    chk("R9 no read", 128'(stat), 128'h0);
    put(8'hE0, 0);

    // random mix
    seed = $urandom(32'd1234);
    for (int n = 0; n < 1500; n++) begin
      int unsigned r = $urandom;
      logic [2:0] c;
      case (r % 8)
        0, 1: c = 3'b000;
        2, 3: c = 3'b010;
        4:    c = 3'b110;
        5:    c = 3'b111;
        default: c = 3'((r >> 3) % 8);
      endcase
      snap = {c, 5'((r >> 8) % 32)};
      if ((r >> 16) % 5 == 0) snap = m_last;
      put(snap, ((r >> 20) % 4) == 0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule